// File: doc/BRIEF.md
# Interrupt Request Dispatch Unit

This block takes a snapshot of a processor's pending interrupt requests and services exactly one of them per accepted request. Seven request kinds are recognised: local-controller poll, startup inter-processor interrupt, system-management interrupt, non-maskable interrupt, machine check, external hardware interrupt and virtual hardware interrupt. For the request it picks, it reports the action to take, the vector to deliver, whether that delivery is a hardware interrupt, an intercept-check strobe with its exit code, and the pending bits that remain afterwards. It also updates the NMI-blocked flag and the virtual-IRQ control bit.

Which requests count as pending is decided upstream; the delivery through the descriptor tables and any guest-exit handling happen downstream. Servicing a single request per call keeps the sequence of events deterministic, so that a replayed run sees the same order. A caller offers a request with `in_valid` while `in_ready` is high. The answer appears one cycle later as a single-cycle `out_valid` pulse with every result field registered.

Top module: `irqd_dispatch`

## Requirements
- R1: `in_ready` is high whenever `out_valid` is low. A request accepted on a rising edge (`in_valid` and `in_ready` both high) gives `out_valid` high for exactly the next cycle, and `in_ready` is low in that cycle.
- R2: Pending bit positions are: 0 poll, 1 startup IPI, 2 SMI, 3 NMI, 4 machine check, 5 external hardware, 6 virtual hardware. Only the set bit with the lowest index is serviced. Bits that are not cleared by that request pass to `pend_out` unchanged, and no bit is ever set.
- R3: With `pend_in` all zero, the result has `taken`=0, `action`=0 (none), `vector`=0, `hw_int`=0, no intercept strobe, and `pend_out`=0. The two flags pass through unchanged.
- R4: Poll gives `action`=1, clears bit 0 only, and delivers no vector (`vector`=0, `hw_int`=0). It raises no intercept strobe.
- R5: Startup IPI gives `action`=2 with no vector and no intercept strobe. It leaves all pending bits unchanged, because clearing that bit is left to the startup sequencer.
- R6: SMI gives `action`=3, clears bit 2, and raises the intercept strobe with code 0x62.
- R7: NMI gives `action`=4 (deliver), `vector`=2 and `hw_int`=1. It clears bit 3, sets the NMI-blocked flag, and raises the intercept strobe with code 0x61.
- R8: Machine check gives `action`=4, `vector`=18 and `hw_int`=0. It clears bit 4 and raises no intercept strobe.
- R9: External hardware gives `action`=4, `vector`=`ext_vec` and `hw_int`=1. It clears both bit 5 and bit 6 and raises the intercept strobe with code 0x60.
- R10: Virtual hardware gives `action`=4, `vector`=`virt_vec` and `hw_int`=1. It clears bit 6, clears the virtual-IRQ control bit, and raises the intercept strobe with code 0x64.
- R11: `nmi_blk_out` equals `nmi_blk_in` except after an NMI, and `virq_ctl_out` equals `virq_ctl_in` except after a virtual hardware request. `taken` is 1 whenever `pend_in` was non-zero.
- R12: Immediately after reset, `out_valid`, `taken` and `icpt_strobe` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Unit can accept a request |
| pend_in | input | 7 | Pending request bits |
| ext_vec | input | 8 | Vector from the external interrupt controller |
| virt_vec | input | 8 | Vector from the virtual-interrupt control field |
| nmi_blk_in | input | 1 | Current NMI-blocked flag |
| virq_ctl_in | input | 1 | Current virtual-IRQ control bit |
| out_valid | output | 1 | Result valid (one cycle) |
| taken | output | 1 | A request was serviced |
| action | output | 3 | 0 none, 1 poll, 2 startup IPI, 3 enter SMM, 4 deliver vector |
| vector | output | 8 | Vector to deliver |
| hw_int | output | 1 | Delivery marked as hardware interrupt |
| icpt_strobe | output | 1 | Intercept check requested |
| icpt_code | output | 8 | Exit code for the intercept check |
| pend_out | output | 7 | Pending bits after servicing |
| nmi_blk_out | output | 1 | Updated NMI-blocked flag |
| virq_ctl_out | output | 1 | Updated virtual-IRQ control bit |

## Verification
Every result field sits in one register stage. All fields are therefore due in the cycle right after the accepting edge, and they are held only while `out_valid` is high. The driver changes inputs on falling edges and pushes the expected result, worked out from the rules above, into a queue as it offers each request. The monitor samples on the falling edge that follows the accepting edge, pops one expectation for every `out_valid` pulse, and flags any pulse that has no matching request. All 128 pending patterns are swept, with varied vectors and flag values, so that priority order and pass-through are covered.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int NREQ   = 7;
    localparam int VEC_W  = 8;
    localparam int CODE_W = 8;
    localparam int ACT_W  = 3;

    localparam int IX_POLL = 0;
    localparam int IX_SIPI = 1;
    localparam int IX_SMI  = 2;
    localparam int IX_NMI  = 3;
    localparam int IX_MCE  = 4;
    localparam int IX_HARD = 5;
    localparam int IX_VIRQ = 6;

    localparam logic [VEC_W-1:0]  NMI_VECTOR  = VEC_W'(2);
    localparam logic [VEC_W-1:0]  MCE_VECTOR  = VEC_W'(18);
    localparam logic [CODE_W-1:0] CODE_INTR   = CODE_W'(8'h60);
    localparam logic [CODE_W-1:0] CODE_NMI    = CODE_W'(8'h61);
    localparam logic [CODE_W-1:0] CODE_SMI    = CODE_W'(8'h62);
    localparam logic [CODE_W-1:0] CODE_VINTR  = CODE_W'(8'h64);

    typedef enum logic [ACT_W-1:0] {
        ACT_NONE    = 3'd0,
        ACT_POLL    = 3'd1,
        ACT_SIPI    = 3'd2,
        ACT_SMM     = 3'd3,
        ACT_DELIVER = 3'd4
    } irqd_act_e;

    typedef struct packed {
        irqd_act_e          act;
        logic [VEC_W-1:0]   vec;
        logic               hw;
        logic               icpt;
        logic [CODE_W-1:0]  code;
        logic [NREQ-1:0]    clr;
        logic               set_nmi;
        logic               clr_virq;
    } irqd_plan_t;

    function automatic logic [NREQ-1:0] lowest_one(input logic [NREQ-1:0] v);
        return v & (~v + NREQ'(1));
    endfunction
endpackage

// File: rtl/irqd_pick.sv
module irqd_pick
    import irqd_pkg::*;
(
    input  logic [NREQ-1:0] pend,
    output logic [NREQ-1:0] grant
);
    for (genvar i = 0; i < NREQ; i++) begin : g_pri
        if (i == 0) begin : g_first
            assign grant[i] = pend[i];
        end else begin : g_rest
            assign grant[i] = pend[i] & ~(|pend[i-1:0]);
        end
    end
endmodule

// File: rtl/irqd_plan.sv
module irqd_plan
    import irqd_pkg::*;
(
    input  logic [NREQ-1:0]  grant,
    input  logic [VEC_W-1:0] ext_vec,
    input  logic [VEC_W-1:0] virt_vec,
    output irqd_plan_t       plan
);
    always_comb begin
        plan = '0;
        plan.act = ACT_NONE;
        if (grant[IX_POLL]) begin
            plan.act = ACT_POLL;
            plan.clr[IX_POLL] = 1'b1;
        end else if (grant[IX_SIPI]) begin
            plan.act = ACT_SIPI;
        end else if (grant[IX_SMI]) begin
            plan.act  = ACT_SMM;
            plan.icpt = 1'b1;
            plan.code = CODE_SMI;
            plan.clr[IX_SMI] = 1'b1;
        end else if (grant[IX_NMI]) begin
            plan.act     = ACT_DELIVER;
            plan.icpt    = 1'b1;
            plan.code    = CODE_NMI;
            plan.vec     = NMI_VECTOR;
            plan.hw      = 1'b1;
            plan.set_nmi = 1'b1;
            plan.clr[IX_NMI] = 1'b1;
        end else if (grant[IX_MCE]) begin
            plan.act = ACT_DELIVER;
            plan.vec = MCE_VECTOR;
            plan.clr[IX_MCE] = 1'b1;
        end else if (grant[IX_HARD]) begin
            plan.act  = ACT_DELIVER;
            plan.icpt = 1'b1;
            plan.code = CODE_INTR;
            plan.vec  = ext_vec;
            plan.hw   = 1'b1;
            plan.clr[IX_HARD] = 1'b1;
            plan.clr[IX_VIRQ] = 1'b1;
        end else if (grant[IX_VIRQ]) begin
            plan.act      = ACT_DELIVER;
            plan.icpt     = 1'b1;
            plan.code     = CODE_VINTR;
            plan.vec      = virt_vec;
            plan.hw       = 1'b1;
            plan.clr_virq = 1'b1;
            plan.clr[IX_VIRQ] = 1'b1;
        end
    end
endmodule

// File: rtl/irqd_dispatch.sv
module irqd_dispatch
    import irqd_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [NREQ-1:0]      pend_in,
    input  logic [VEC_W-1:0]     ext_vec,
    input  logic [VEC_W-1:0]     virt_vec,
    input  logic                 nmi_blk_in,
    input  logic                 virq_ctl_in,
    output logic                 out_valid,
    output logic                 taken,
    output logic [ACT_W-1:0]     action,
    output logic [VEC_W-1:0]     vector,
    output logic                 hw_int,
    output logic                 icpt_strobe,
    output logic [CODE_W-1:0]    icpt_code,
    output logic [NREQ-1:0]      pend_out,
    output logic                 nmi_blk_out,
    output logic                 virq_ctl_out
);
    logic [NREQ-1:0] grant;
    irqd_plan_t      plan;
    logic            accept;

    irqd_pick u_pick (.pend(pend_in), .grant(grant));

    irqd_plan u_plan (
        .grant    (grant),
        .ext_vec  (ext_vec),
        .virt_vec (virt_vec),
        .plan     (plan)
    );

    assign in_ready = ~out_valid;
    assign accept   = in_valid & in_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid    <= 1'b0;
            taken        <= 1'b0;
            icpt_strobe  <= 1'b0;
            action       <= ACT_NONE;
            vector       <= '0;
            hw_int       <= 1'b0;
            icpt_code    <= '0;
            pend_out     <= '0;
            nmi_blk_out  <= 1'b0;
            virq_ctl_out <= 1'b0;
        end else if (accept) begin
            out_valid    <= 1'b1;
            taken        <= |grant;
            icpt_strobe  <= plan.icpt;
            action       <= plan.act;
            vector       <= plan.vec;
            hw_int       <= plan.hw;
            icpt_code    <= plan.code;
            pend_out     <= pend_in & ~plan.clr;
            nmi_blk_out  <= nmi_blk_in | plan.set_nmi;
            virq_ctl_out <= virq_ctl_in & ~plan.clr_virq;
        end else begin
            out_valid    <= 1'b0;
            taken        <= 1'b0;
            icpt_strobe  <= 1'b0;
        end
    end
endmodule

// File: rtl/irqd_dispatch_chk.sv
module irqd_dispatch_chk
    import irqd_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [NREQ-1:0]   pend_in,
    input logic              nmi_blk_in,
    input logic              virq_ctl_in,
    input logic              out_valid,
    input logic              taken,
    input logic [ACT_W-1:0]  action,
    input logic [VEC_W-1:0]  vector,
    input logic              icpt_strobe,
    input logic [NREQ-1:0]   pend_out,
    input logic              nmi_blk_out,
    input logic              virq_ctl_out
);
    logic [NREQ-1:0] cap_pend;
    logic            cap_nmi;
    logic            cap_virq;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_pend <= '0;
            cap_nmi  <= 1'b0;
            cap_virq <= 1'b0;
        end else if (in_valid && in_ready) begin
            cap_pend <= pend_in;
            cap_nmi  <= nmi_blk_in;
            cap_virq <= virq_ctl_in;
        end
    end

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid); // R1
    AST_BUSY_NO_READY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !in_ready); // R1
    AST_NO_SET_BITS: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((pend_out & ~cap_pend) == '0)); // R2
    AST_LOWEST_SERVED: assert property (@(posedge clk) disable iff (rst)
        (out_valid && taken && action != ACT_SIPI) |-> ((pend_out & lowest_one(cap_pend)) == '0)); // R2
    AST_EMPTY_IDLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cap_pend == '0) |-> (!taken && !icpt_strobe)); // R3
    AST_STROBE_TAKEN: assert property (@(posedge clk) disable iff (rst)
        icpt_strobe |-> (taken && out_valid)); // R6
    AST_NMI_FLAG: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !cap_nmi && nmi_blk_out) |-> (action == ACT_DELIVER && vector == NMI_VECTOR)); // R7
    AST_VIRQ_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cap_virq && !virq_ctl_out) |-> (cap_pend[IX_VIRQ] && !pend_out[IX_VIRQ])); // R10
    AST_TAKEN_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (taken == (cap_pend != '0))); // R11
endmodule

bind irqd_dispatch irqd_dispatch_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .pend_in      (pend_in),
    .nmi_blk_in   (nmi_blk_in),
    .virq_ctl_in  (virq_ctl_in),
    .out_valid    (out_valid),
    .taken        (taken),
    .action       (action),
    .vector       (vector),
    .icpt_strobe  (icpt_strobe),
    .pend_out     (pend_out),
    .nmi_blk_out  (nmi_blk_out),
    .virq_ctl_out (virq_ctl_out)
);

// File: tb/tb_irqd_dispatch.sv
module tb_irqd_dispatch;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [6:0] pend_in = '0;
    logic [7:0] ext_vec = '0;
    logic [7:0] virt_vec = '0;
    logic       nmi_blk_in = 1'b0;
    logic       virq_ctl_in = 1'b0;
    logic       out_valid, taken, hw_int, icpt_strobe, nmi_blk_out, virq_ctl_out;
    logic [2:0] action;
    logic [7:0] vector, icpt_code;
    logic [6:0] pend_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [30:0] exp_q[$];
    string       tag_q[$];

    irqd_dispatch dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .pend_in(pend_in), .ext_vec(ext_vec), .virt_vec(virt_vec),
        .nmi_blk_in(nmi_blk_in), .virq_ctl_in(virq_ctl_in),
        .out_valid(out_valid), .taken(taken), .action(action), .vector(vector),
        .hw_int(hw_int), .icpt_strobe(icpt_strobe), .icpt_code(icpt_code),
        .pend_out(pend_out), .nmi_blk_out(nmi_blk_out), .virq_ctl_out(virq_ctl_out)
    );

    always #5 clk = ~clk;

    // layout: taken, action[3], vector[8], hw, strobe, code[8], pend[7], nmi, virq
    function automatic logic [30:0] model(input logic [6:0] p, input logic [7:0] ev,
                                          input logic [7:0] vv, input logic n, input logic v,
                                          output string tag);
        logic t = 1'b0, hw = 1'b0, st = 1'b0;
        logic [2:0] a = 3'd0;
        logic [7:0] vec = 8'd0, code = 8'd0;
        logic [6:0] po = p;
        logic no = n, vo = v;
        tag = "R3";
        if (p[0])      begin t = 1; a = 1; po[0] = 0; tag = "R4"; end
        else if (p[1]) begin t = 1; a = 2; tag = "R5"; end
        else if (p[2]) begin t = 1; a = 3; st = 1; code = 8'h62; po[2] = 0; tag = "R6"; end
        else if (p[3]) begin t = 1; a = 4; st = 1; code = 8'h61; vec = 8'd2; hw = 1; po[3] = 0; no = 1; tag = "R7"; end
        else if (p[4]) begin t = 1; a = 4; vec = 8'd18; po[4] = 0; tag = "R8"; end
        else if (p[5]) begin t = 1; a = 4; st = 1; code = 8'h60; vec = ev; hw = 1; po[5] = 0; po[6] = 0; tag = "R9"; end
        else if (p[6]) begin t = 1; a = 4; st = 1; code = 8'h64; vec = vv; hw = 1; po[6] = 0; vo = 0; tag = "R10"; end
        return {t, a, vec, hw, st, code, po, no, vo};
    endfunction

    task automatic send(input logic [6:0] p, input logic [7:0] ev, input logic [7:0] vv,
                        input logic n, input logic v, input string why);
        string tag;
        logic [30:0] e;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        e = model(p, ev, vv, n, v, tag);
        exp_q.push_back(e);
        tag_q.push_back({tag, " R2 R11 ", why});
        pend_in = p; ext_vec = ev; virt_vec = vv; nmi_blk_in = n; virq_ctl_in = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        pend_in = 7'h55; ext_vec = 8'hEE; virt_vec = 8'hDD;
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (!rst && out_valid) begin
                logic [30:0] got;
                got = {taken, action, vector, hw_int, icpt_strobe, icpt_code, pend_out,
                       nmi_blk_out, virq_ctl_out};
                checks++;
                if (in_ready) begin
                    errors++;
                    $display("FAIL R1 in_ready actual=%0b expected=0", in_ready);
                end
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R1 unexpected out_valid actual=%h expected=none", got);
                end else begin
                    logic [30:0] e;
                    string tg;
                    e = exp_q.pop_front();
                    tg = tag_q.pop_front();
                    if (got !== e) begin
                        errors++;
                        $display("FAIL %s actual=%h expected=%h", tg, got, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (1000000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || taken !== 1'b0 || icpt_strobe !== 1'b0 || in_ready !== 1'b1) begin
            errors++;
            $display("FAIL R12 actual=%b%b%b%b expected=0001", out_valid, taken, icpt_strobe, in_ready);
        end
        send(7'b0000000, 8'h11, 8'h22, 1'b1, 1'b1, "empty");
        send(7'b1111111, 8'h11, 8'h22, 1'b0, 1'b1, "poll wins");
        send(7'b1111110, 8'h11, 8'h22, 1'b0, 1'b0, "sipi");
        send(7'b1111100, 8'h11, 8'h22, 1'b0, 1'b1, "smi");
        send(7'b1111000, 8'h11, 8'h22, 1'b0, 1'b1, "nmi");
        send(7'b1110000, 8'h11, 8'h22, 1'b1, 1'b0, "mce");
        send(7'b1100000, 8'hA7, 8'h22, 1'b0, 1'b1, "hard clears virq");
        send(7'b1000000, 8'h11, 8'h5C, 1'b1, 1'b1, "virq");
        send(7'b0100000, 8'hFF, 8'h00, 1'b1, 1'b0, "hard alone");
        send(7'b0001000, 8'h00, 8'h00, 1'b1, 1'b1, "nmi already blocked");
        for (int i = 0; i < 128; i++) begin
            send(7'(i), 8'(i * 37 + 5), 8'(i * 91 + 3), i[0], i[1], "sweep");
        end
        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R1 missing results actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule